// File: doc/BRIEF.md
# Gossip Flooding Tile for a Mesh Network-on-Chip

This block is a single tile of a mesh network-on-chip. It does not route by address. Instead, messages spread through the mesh by probabilistic flooding. The tile has four neighbour links (north, east, south, west) and one port to its local core. It keeps a send list of at most `LIST_DEPTH` messages. Each message enters the list once, from a neighbour or from the core. The tile drops any arrival whose checksum is wrong, and it never asks for a resend.

Work is split into rounds. A round starts on a pulse of `round_go`. The tile then visits each send-list slot in turn, one slot per clock cycle. For every live slot it decides separately for each link whether to transmit the message. The decision comes from a per-link pseudo-random generator compared against a programmable threshold. Each message carries a hop lifetime that ages once per round and removes the message when it runs out.

A copy that passes the checksum and is addressed to this tile goes to the core. It is delivered again only after the held copy has left the list. The send list therefore also serves as the tile's record of messages already seen.

Top module: `gossip_tile`

## Requirements
- R1: After reset, `tx_valid`, `dlv_valid` and `overflow` are 0, and `rx_ready` and `inj_ready` are all 1.
- R2: A `round_go` pulse while idle starts a sweep of exactly `LIST_DEPTH` consecutive cycles. In sweep cycle i, slot i of the send list is presented on the links. Outside a sweep, `tx_valid` is 0.
- R3: In each sweep cycle, link l transmits when the slot is live and the link's 16-bit LFSR value is below `send_threshold`. The LFSR uses x^16+x^14+x^13+x^11+1: the new bit is the XOR of bits 15, 13, 12 and 10, shifted in at bit 0. The seeds are 0xACE1, 0xC038, 0xD38F and 0xE6E6 for links 0 to 3 (north, east, south, west). Every LFSR steps once per sweep cycle.
- R4: A packet is {src[3:0], seq[3:0], dst[3:0], ttl[7:0], payload[31:0], crc[15:0]}, most significant field first. The CRC uses polynomial 0x1021 with initial value 0xFFFF, fed with the 52 header bits MSB first. A neighbour packet whose CRC mismatches is neither delivered nor stored. Every transmitted packet carries the CRC of its own header.
- R5: An arrival whose (src, seq) matches a message already in the send list is neither stored again nor delivered again.
- R6: A transmitted copy carries the stored ttl minus 1. A live slot's stored ttl drops by 1 after its sweep cycle, and the slot is freed when the ttl reaches 0. An arrival with ttl 0 is not stored.
- R7: A message stored after a round starts is not transmitted or aged in that round. It takes part from the next round on.
- R8: A valid, non-duplicate arrival with dst equal to `MY_ID` (default 5) raises `dlv_valid` for one cycle, carrying its src, seq and payload.
- R9: A non-duplicate arrival with nonzero ttl that finds no free slot is discarded, and `overflow` is set and stays set until reset. New messages go to the lowest free slot.
- R10: Each of the five input ports has a one-entry buffer whose ready is low while it holds a packet. One buffered packet is processed per cycle, in the fixed priority north, east, south, west, core.
- R11: A threshold of 0 never transmits. Thresholds 0x4000, 0x8000 and 0xC000 give send probabilities of 0.25, 0.5 and 0.75.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| round_go | input | 1 | Starts a round when the tile is idle |
| send_threshold | input | 16 | Per-link send threshold compared against the LFSRs |
| rx_valid | input | 4 | Neighbour packet valid, bit 0 north to bit 3 west |
| rx_pkt | input | 272 | Four 68-bit neighbour packets, link l at bits l*68 upward |
| rx_ready | output | 4 | Neighbour edge buffer empty |
| tx_valid | output | 4 | Transmit on link l this cycle |
| tx_pkt | output | 272 | Four 68-bit outgoing packets |
| inj_valid | input | 1 | Core injects a message |
| inj_msg | input | 52 | Injected header {src, seq, dst, ttl, payload} |
| inj_ready | output | 1 | Core edge buffer empty |
| dlv_valid | output | 1 | Delivery to core |
| dlv_src | output | 4 | Source of the delivered message |
| dlv_seq | output | 4 | Sequence number of the delivered message |
| dlv_payload | output | 32 | Payload of the delivered message |
| overflow | output | 1 | Sticky send-list overflow |

## Verification
The bench drives the same message into all four links in one cycle. A wrong arbitration order would then deliver a payload other than the north one. The bench sends a copy with a flipped CRC bit; a design that skipped the check would deliver it and flood it in the next round. It also injects a message in the same cycle that a round starts. A tile without the fresh-entry rule would transmit that message in the current round. Finally, the bench ages messages down to ttl 1 and fills the list past its depth. This exposes off-by-one removal, a wrong ttl in transmitted copies, and an overflow flag that clears or never sets.

// File: rtl/gossip_pkg.sv
package gossip_pkg;
  localparam int ID_W  = 4;
  localparam int SEQ_W = 4;
  localparam int TTL_W = 8;
  localparam int PAY_W = 32;
  localparam int CRC_W = 16;
  localparam int NLINK = 4;
  localparam int HDR_W = 2 * ID_W + SEQ_W + TTL_W + PAY_W;
  localparam int PKT_W = HDR_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef struct packed {
    logic [ID_W-1:0]  src;
    logic [SEQ_W-1:0] seq;
    logic [ID_W-1:0]  dst;
    logic [TTL_W-1:0] ttl;
    logic [PAY_W-1:0] pay;
  } msg_t;

  // Behaves as a shift register fed one header bit per step, MSB first.
  function automatic logic [CRC_W-1:0] hdr_crc(input msg_t m);
    logic [HDR_W-1:0] bits;
    logic [CRC_W-1:0] sr;
    logic             fb;
    bits = m;
    sr   = CRC_INIT;
    for (int i = HDR_W - 1; i >= 0; i--) begin
      fb = sr[CRC_W-1] ^ bits[i];
      sr = {sr[CRC_W-2:0], 1'b0};
      if (fb) sr = sr ^ CRC_POLY;
    end
    return sr;
  endfunction

  function automatic logic [15:0] lfsr_seed(input int l);
    return 16'hACE1 + 16'(l) * 16'h1357;
  endfunction
endpackage

// File: rtl/gossip_lfsr.sv
module gossip_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [15:0] value
);
  logic [15:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step) lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign value = lfsr_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 16'h0); // R3
endmodule

// File: rtl/gossip_edge_buf.sv
module gossip_edge_buf #(
  parameter int W = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         in_ready,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q, full_d;
  logic [W-1:0] data_q;
  logic         load_en;

  assign load_en = !full_q && in_valid;

  always_comb begin
    full_d = full_q;
    if (full_q && pop) full_d = 1'b0;
    else if (load_en)  full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= in_data;
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign data     = data_q;

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop) |=> (full_q && $stable(data_q))); // R10
endmodule

// File: rtl/gossip_send_list.sv
module gossip_send_list
  import gossip_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_fresh,
  input  logic                     ins_en,
  input  msg_t                     ins_msg,
  input  logic                     slot_step,
  input  logic [$clog2(DEPTH)-1:0] slot_idx,
  output logic                     match,
  output logic                     full,
  output msg_t                     slot_msg,
  output logic                     slot_live
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] vld_q, vld_d, frs_q, frs_d;
  msg_t             mem_q [DEPTH];
  msg_t             mem_d [DEPTH];
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    match = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && mem_q[i].src == ins_msg.src && mem_q[i].seq == ins_msg.seq) match = 1'b1;
    end
  end

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign full      = &vld_q;
  assign slot_msg  = mem_q[slot_idx];
  assign slot_live = vld_q[slot_idx] && !frs_q[slot_idx];

  always_comb begin
    vld_d = vld_q;
    frs_d = frs_q;
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (clr_fresh) frs_d = '0;
    if (slot_step && slot_live) begin
      if (mem_q[slot_idx].ttl == TTL_W'(1)) vld_d[slot_idx] = 1'b0;
      else mem_d[slot_idx].ttl = mem_q[slot_idx].ttl - TTL_W'(1);
    end
    if (ins_en && free_found) begin
      vld_d[free_idx] = 1'b1;
      frs_d[free_idx] = 1'b1;
      mem_d[free_idx] = ins_msg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      frs_q <= '0;
    end else begin
      vld_q <= vld_d;
      frs_q <= frs_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_LIVE_TTL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[g] |-> (mem_q[g].ttl != '0)); // R6
  end
endmodule

// File: rtl/gossip_tile.sv
module gossip_tile
  import gossip_pkg::*;
#(
  parameter logic [3:0] MY_ID      = 4'd5,
  parameter int         LIST_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     round_go,
  input  logic [15:0]              send_threshold,
  input  logic [NLINK-1:0]         rx_valid,
  input  logic [NLINK*PKT_W-1:0]   rx_pkt,
  output logic [NLINK-1:0]         rx_ready,
  output logic [NLINK-1:0]         tx_valid,
  output logic [NLINK*PKT_W-1:0]   tx_pkt,
  input  logic                     inj_valid,
  input  logic [HDR_W-1:0]         inj_msg,
  output logic                     inj_ready,
  output logic                     dlv_valid,
  output logic [ID_W-1:0]          dlv_src,
  output logic [SEQ_W-1:0]         dlv_seq,
  output logic [PAY_W-1:0]         dlv_payload,
  output logic                     overflow
);
  localparam int NPORT = NLINK + 1;
  localparam int IDX_W = $clog2(LIST_DEPTH);

  // Edge buffers: links then core, lowest index has priority
  logic [NPORT-1:0] b_in_v, b_rdy, b_full, grant;
  logic [PKT_W-1:0] b_in_d [NPORT];
  logic [PKT_W-1:0] b_data [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_edge
    if (p < NLINK) begin : g_link
      assign b_in_v[p] = rx_valid[p];
      assign b_in_d[p] = rx_pkt[p*PKT_W +: PKT_W];
    end else begin : g_core
      assign b_in_v[p] = inj_valid;
      assign b_in_d[p] = {inj_msg, {CRC_W{1'b0}}};
    end
    gossip_edge_buf #(.W(PKT_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(b_in_v[p]),
      .in_data (b_in_d[p]),
      .pop     (grant[p]),
      .in_ready(b_rdy[p]),
      .full    (b_full[p]),
      .data    (b_data[p])
    );
  end

  assign rx_ready  = b_rdy[NLINK-1:0];
  assign inj_ready = b_rdy[NLINK];

  logic [PKT_W-1:0] sel_pkt;
  always_comb begin
    grant   = '0;
    sel_pkt = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (b_full[p] && grant == '0) begin
        grant[p] = 1'b1;
        sel_pkt  = b_data[p];
      end
    end
  end

  // Classification of the selected arrival
  msg_t       cand;
  logic       crc_ok, accepted, is_dup, list_full, do_insert, do_deliver, ovf_set;
  assign cand       = sel_pkt[PKT_W-1 -: HDR_W];
  assign crc_ok     = grant[NLINK] || (hdr_crc(cand) == sel_pkt[CRC_W-1:0]);
  assign accepted   = (|grant) && crc_ok;
  assign do_deliver = accepted && !is_dup && (cand.dst == MY_ID);
  assign do_insert  = accepted && !is_dup && (cand.ttl != '0) && !list_full;
  assign ovf_set    = accepted && !is_dup && (cand.ttl != '0) && list_full;

  // Round sweep control
  logic             sweep_q, sweep_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             start_round;
  assign start_round = round_go && !sweep_q;

  always_comb begin
    sweep_d = sweep_q;
    ptr_d   = ptr_q;
    if (start_round) begin
      sweep_d = 1'b1;
      ptr_d   = '0;
    end else if (sweep_q) begin
      if (ptr_q == IDX_W'(LIST_DEPTH - 1)) begin
        sweep_d = 1'b0;
        ptr_d   = '0;
      end else begin
        ptr_d = ptr_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      sweep_q <= sweep_d;
      ptr_q   <= ptr_d;
    end
  end

  msg_t slot_msg;
  logic slot_live;

  gossip_send_list #(.DEPTH(LIST_DEPTH)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_fresh(start_round),
    .ins_en   (do_insert),
    .ins_msg  (cand),
    .slot_step(sweep_q),
    .slot_idx (ptr_q),
    .match    (is_dup),
    .full     (list_full),
    .slot_msg (slot_msg),
    .slot_live(slot_live)
  );

  // Transmit path: one aged copy, per-link random gate
  msg_t             tx_m;
  logic [CRC_W-1:0] tx_crc;
  logic [15:0]      lfsr_v [NLINK];

  always_comb begin
    tx_m     = slot_msg;
    tx_m.ttl = slot_msg.ttl - TTL_W'(1);
  end
  assign tx_crc = hdr_crc(tx_m);

  for (genvar l = 0; l < NLINK; l++) begin : g_link_tx
    gossip_lfsr #(.SEED(lfsr_seed(l))) u_lfsr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (sweep_q),
      .value(lfsr_v[l])
    );
    assign tx_valid[l]               = sweep_q && slot_live && (lfsr_v[l] < send_threshold);
    assign tx_pkt[l*PKT_W +: PKT_W]  = {tx_m, tx_crc};
  end

  // Delivery and overflow registers
  logic             dlv_v_q, ovf_q, ovf_d;
  logic [ID_W-1:0]  dlv_src_q;
  logic [SEQ_W-1:0] dlv_seq_q;
  logic [PAY_W-1:0] dlv_pay_q;

  assign ovf_d = ovf_q || ovf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_v_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      dlv_v_q <= do_deliver;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_deliver) begin
      dlv_src_q <= cand.src;
      dlv_seq_q <= cand.seq;
      dlv_pay_q <= cand.pay;
    end
  end

  assign dlv_valid   = dlv_v_q;
  assign dlv_src     = dlv_src_q;
  assign dlv_seq     = dlv_seq_q;
  assign dlv_payload = dlv_pay_q;
  assign overflow    = ovf_q;

  AST_ROUND_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_q) |-> $past(round_go)); // R2
  AST_SWEEP_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_q) |-> ($past(ptr_q) == IDX_W'(LIST_DEPTH - 1))); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_DLV_FROM_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $past(|b_full)); // R8
endmodule

// File: tb/gossip_tile_tb.sv
module gossip_tile_tb_top;
  localparam int PW = 68;
  localparam logic [3:0] ME = 4'd5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          round_go;
  logic [15:0]   thr;
  logic [3:0]    rx_valid;
  logic [4*PW-1:0] rx_pkt;
  logic [3:0]    rx_ready;
  logic [3:0]    tx_valid;
  logic [4*PW-1:0] tx_pkt;
  logic          inj_valid;
  logic [51:0]   inj_msg;
  logic          inj_ready;
  logic          dlv_valid;
  logic [3:0]    dlv_src;
  logic [3:0]    dlv_seq;
  logic [31:0]   dlv_payload;
  logic          overflow;

  always #10 clk = ~clk;

  gossip_tile dut_i (
    .clk(clk), .rst_n(rst_n), .round_go(round_go), .send_threshold(thr),
    .rx_valid(rx_valid), .rx_pkt(rx_pkt), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_pkt(tx_pkt),
    .inj_valid(inj_valid), .inj_msg(inj_msg), .inj_ready(inj_ready),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_seq(dlv_seq),
    .dlv_payload(dlv_payload), .overflow(overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [51:0] m_hdr [8];
  bit          m_v [8];
  bit          m_f [8];
  logic [15:0] m_lfsr [4];
  bit          m_ovf;
  logic [39:0] exp_dlv [$];
  logic [39:0] got_dlv [$];
  bit          in_sweep;
  logic [67:0] drv [5];

  function automatic logic [15:0] ref_crc(input logic [51:0] h);
    logic [15:0] c = 16'hFFFF;
    for (int i = 51; i >= 0; i--) begin
      c = c ^ {h[i], 15'b0};
      if (c[15]) c = (c << 1) ^ 16'h1021;
      else       c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [51:0] mk(input logic [3:0] s, input logic [3:0] q, input logic [3:0] d,
                                     input logic [7:0] t, input logic [31:0] p);
    return {s, q, d, t, p};
  endfunction

  function automatic logic [67:0] pk(input logic [51:0] h);
    return {h, ref_crc(h)};
  endfunction

  task automatic model_accept(input logic [67:0] p, input bit local_src);
    logic [51:0] h = p[67:16];
    bit dup = 0;
    bit placed = 0;
    if (!local_src && ref_crc(h) != p[15:0]) return;
    for (int i = 0; i < 8; i++)
      if (m_v[i] && m_hdr[i][51:44] == h[51:44]) dup = 1;
    if (dup) return;
    if (h[43:40] == ME) exp_dlv.push_back({h[51:44], h[31:0]});
    if (h[39:32] == 8'd0) return;
    for (int i = 0; i < 8; i++)
      if (!m_v[i] && !placed) begin
        m_v[i] = 1; m_f[i] = 1; m_hdr[i] = h; placed = 1;
      end
    if (!placed) m_ovf = 1;
  endtask

  always @(negedge clk) begin
    if (rst_n && dlv_valid) got_dlv.push_back({dlv_src, dlv_seq, dlv_payload});
    if (rst_n && !in_sweep) check(tx_valid == 4'b0, "R2 idle", 128'(tx_valid), 128'(0));
  end

  task automatic flush_dlv(input string req);
    check(got_dlv.size() == exp_dlv.size(), req, 128'(got_dlv.size()), 128'(exp_dlv.size()));
    while (got_dlv.size() > 0 && exp_dlv.size() > 0) begin
      logic [39:0] g = got_dlv.pop_front();
      logic [39:0] e = exp_dlv.pop_front();
      check(g == e, req, 128'(g), 128'(e));
    end
    got_dlv.delete();
    exp_dlv.delete();
  endtask

  // drive ports given by mask (bit 4 = core) for one cycle
  task automatic send_batch(input logic [4:0] mask, input string req);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      rx_valid[p] = mask[p];
      rx_pkt[p*PW +: PW] = drv[p];
    end
    inj_valid = mask[4];
    inj_msg   = drv[4][67:16];
    @(negedge clk);
    rx_valid  = '0;
    inj_valid = 1'b0;
    check(rx_ready == ~mask[3:0], "R10 ready", 128'(rx_ready), 128'(~mask[3:0]));
    check(inj_ready == ~mask[4], "R10 ready", 128'(inj_ready), 128'(~mask[4]));
    repeat (7) @(negedge clk);
    for (int p = 0; p < 5; p++) if (mask[p]) model_accept(drv[p], p == 4);
    flush_dlv(req);
    check(overflow == m_ovf, "R9 overflow", 128'(overflow), 128'(m_ovf));
  endtask

  task automatic do_round(input logic [15:0] t, input bit with_inj, input logic [51:0] ih, input string req);
    @(negedge clk);
    thr = t;
    round_go = 1'b1;
    in_sweep = 1;
    if (with_inj) begin
      inj_valid = 1'b1;
      inj_msg   = ih;
    end
    @(negedge clk);
    round_go  = 1'b0;
    inj_valid = 1'b0;
    for (int i = 0; i < 8; i++) m_f[i] = 0;
    if (with_inj) model_accept({ih, 16'h0}, 1);
    for (int s = 0; s < 8; s++) begin
      bit live = m_v[s] && !m_f[s];
      logic [51:0] h = m_hdr[s];
      h[39:32] = h[39:32] - 8'd1;
      for (int l = 0; l < 4; l++) begin
        bit ev = live && (m_lfsr[l] < t);
        check(tx_valid[l] == ev, req, 128'(tx_valid[l]), 128'(ev));
        if (ev) check(tx_pkt[l*PW +: PW] == pk(h), req, 128'(tx_pkt[l*PW +: PW]), 128'(pk(h)));
      end
      for (int l = 0; l < 4; l++)
        m_lfsr[l] = {m_lfsr[l][14:0], m_lfsr[l][15] ^ m_lfsr[l][13] ^ m_lfsr[l][12] ^ m_lfsr[l][10]};
      if (live) begin
        if (m_hdr[s][39:32] == 8'd1) m_v[s] = 0;
        else m_hdr[s][39:32] = m_hdr[s][39:32] - 8'd1;
      end
      @(negedge clk);
    end
    in_sweep = 0;
    repeat (2) @(negedge clk);
    flush_dlv("R8 round");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; round_go = 1'b0; thr = 16'h0; rx_valid = '0; rx_pkt = '0;
    inj_valid = 1'b0; inj_msg = '0; in_sweep = 0; m_ovf = 0;
    m_lfsr[0] = 16'hACE1; m_lfsr[1] = 16'hC038; m_lfsr[2] = 16'hD38F; m_lfsr[3] = 16'hE6E6;
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_f[i] = 0; m_hdr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_valid == 4'b0, "R1", 128'(tx_valid), 128'(0));
    check(dlv_valid == 1'b0, "R1", 128'(dlv_valid), 128'(0));
    check(overflow == 1'b0, "R1", 128'(overflow), 128'(0));
    check(rx_ready == 4'hF && inj_ready, "R1", 128'({rx_ready, inj_ready}), 128'(5'h1F));

    // R8: addressed delivery plus a pass-through message
    drv[0] = pk(mk(4'd1, 4'd1, ME,   8'd3, 32'hA0A0_0001));
    drv[1] = pk(mk(4'd2, 4'd1, 4'd9, 8'd2, 32'hB0B0_0002));
    send_batch(5'b00011, "R8 deliver");
    do_round(16'h8000, 0, '0, "R2 R3 R11 p0.5");

    // R5: duplicate on south
    drv[2] = pk(mk(4'd1, 4'd1, ME, 8'd7, 32'hA0A0_0001));
    send_batch(5'b00100, "R5 dup");
    do_round(16'hC000, 0, '0, "R5 R11 p0.75");

    // R4: corrupted CRC on west
    drv[3] = pk(mk(4'd3, 4'd2, ME, 8'd6, 32'hC0C0_0003)) ^ 68'h1;
    send_batch(5'b01000, "R4 bad crc");
    do_round(16'h4000, 0, '0, "R4 R6 R11 p0.25");

    // R10: same message on all links, north wins
    for (int p = 0; p < 4; p++) drv[p] = pk(mk(4'd2, 4'd3, ME, 8'd4, 32'hD000_0000 + p));
    send_batch(5'b01111, "R10 priority");

    // R6: ttl 0 arrival is not stored
    drv[0] = pk(mk(4'd4, 4'd1, 4'd9, 8'd0, 32'hE0E0_0005));
    send_batch(5'b00001, "R6 ttl0");
    do_round(16'hFFFF, 0, '0, "R6 aging");
    do_round(16'h0000, 0, '0, "R11 zero threshold");

    // R7: message stored during a round waits for the next
    do_round(16'hFFFF, 1, mk(4'd6, 4'd2, 4'd3, 8'd5, 32'hF0F0_0006), "R7 fresh");
    do_round(16'hFFFF, 0, '0, "R7 next round");

    // R9: overfill the list from the core
    for (int j = 0; j < 9; j++) begin
      drv[4] = {mk(4'd7, 4'(j), 4'd1, 8'd9, 32'h7000_0000 + j), 16'h0};
      send_batch(5'b10000, "R9 fill");
    end
    do_round(16'h8000, 0, '0, "R9 after overflow");
    check(overflow == 1'b1, "R9 sticky", 128'(overflow), 128'(1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule